// File: doc/BRIEF.md
# Multi-Channel Serial Port Register Front End

This block is the register-facing half of a serial port peripheral that serves several channels from one 32-bit bus port. Each channel has its own window of 0x4000 bytes. An access is split into a channel number and a register offset within that window. Each channel keeps a set of configuration and status words that software can load and read back. It also has a transmit data port and a receive data port, and accesses to these two ports have side effects.

A write to a channel's transmit port produces a one-cycle byte strobe for the serial engine. It also marks the channel's transmitter as empty. If the channel's interrupt mode field selects pulse mode, it also sends a one-cycle transmit sub-interrupt toward the interrupt controller. When the serial engine presents a received byte with a valid pulse, the block stores that byte and raises the receive-ready flags. A read of the receive port returns the byte and clears those flags. Bit timing and FIFOs belong to neighbouring blocks.

Top module: `uart_chan_regif`

## Requirements
- R1: The channel number is `bus_addr[ADDR_W-1:14]` and the register offset is `bus_addr[13:0]`. An access whose channel number is `NUM_CH` or higher reaches no channel. An access to one channel never changes another channel's registers.
- R2: The following registers load all 32 bits on a write and return them on a read: 0x000 control, 0x004 line setup, 0x008 baud divisor, 0x00C FIFO setup, 0x010 modem setup, 0x014 transfer status, 0x018 FIFO status, 0x01C error status and 0x020 modem status. Read data appears on `bus_rdata` in the cycle after the read access.
- R3: After reset, `bus_rdata` and every register read zero, with one exception: transfer status reads 0x00000006.
- R4: A write to the transmit port (offset 0x024) of channel c drives `tx_stb` to exactly `1<<c` for the one cycle after the write, with `tx_byte` equal to `bus_wdata[7:0]`. It ORs 0x6 into that channel's transfer status, and `tx_stb` has no other cause.
- R5: `tx_irq[c]` pulses in the same cycle as `tx_stb[c]` only when bits [3:2] of channel c's control register equal 2'b01. In the other three modes it stays low.
- R6: A read of the receive port (offset 0x028) returns the stored byte in bits [7:0] with zeros above. It clears bit 0 of both transfer status and FIFO status and leaves their other bits unchanged.
- R7: A pulse on `rx_valid[c]` stores `rx_byte[8c+7:8c]` and sets bit 0 of both of channel c's status registers. When the pulse and a receive-port read fall in the same cycle, the read returns the old byte and bit 0 ends up set.
- R8: A write to an unmapped offset, to the receive port, or to a channel number at or above `NUM_CH` changes no register and raises no strobe. A read of such an offset, or of the transmit port, leaves `bus_rdata` unchanged.
- R9: `bus_rdata` holds its value in every cycle that has no mapped read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset from the peripheral base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | NUM_CH | Received-byte pulse per channel |
| rx_byte | input | 8*NUM_CH | Received byte per channel |
| tx_stb | output | NUM_CH | Transmit byte strobe per channel |
| tx_byte | output | 8 | Byte for the strobed channel |
| tx_irq | output | NUM_CH | Transmit sub-interrupt pulse per channel |

## Verification
The assertions check four properties on every cycle: transmit strobes are one-hot, each strobe follows a transmit-port write, no interrupt pulse appears without its strobe, and the read data holds whenever no mapped read occurs. Only the bench scenarios can show the stored values. These include the register readback across all channels, the reset contents, the status bits set and cleared by the data ports, the interrupt mode decode, and the rule that a received byte wins over a clear in the same cycle.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned WIN_SHIFT = 14;

  localparam logic [WIN_SHIFT-1:0] OFF_CTRL      = 14'h000;
  localparam logic [WIN_SHIFT-1:0] OFF_LINE      = 14'h004;
  localparam logic [WIN_SHIFT-1:0] OFF_BAUD      = 14'h008;
  localparam logic [WIN_SHIFT-1:0] OFF_FIFOCTL   = 14'h00C;
  localparam logic [WIN_SHIFT-1:0] OFF_MODEMCTL  = 14'h010;
  localparam logic [WIN_SHIFT-1:0] OFF_TRSTAT    = 14'h014;
  localparam logic [WIN_SHIFT-1:0] OFF_FIFOSTAT  = 14'h018;
  localparam logic [WIN_SHIFT-1:0] OFF_ERRSTAT   = 14'h01C;
  localparam logic [WIN_SHIFT-1:0] OFF_MODEMSTAT = 14'h020;
  localparam logic [WIN_SHIFT-1:0] OFF_TXDATA    = 14'h024;
  localparam logic [WIN_SHIFT-1:0] OFF_RXDATA    = 14'h028;

  localparam logic [WORD_W-1:0] TRSTAT_RESET = 32'h0000_0006;
  localparam logic [WORD_W-1:0] TX_EMPTY_SET = 32'h0000_0006;
  localparam logic [1:0]        IRQ_MODE_PULSE = 2'b01;

  typedef enum logic [3:0] {
    REG_CTRL, REG_LINE, REG_BAUD, REG_FIFOCTL, REG_MODEMCTL,
    REG_TRSTAT, REG_FIFOSTAT, REG_ERRSTAT, REG_MODEMSTAT,
    REG_TXDATA, REG_RXDATA, REG_NONE
  } reg_sel_e;

  function automatic reg_sel_e offset_to_reg(input logic [WIN_SHIFT-1:0] off);
    reg_sel_e r;
    case (off)
      OFF_CTRL:      r = REG_CTRL;
      OFF_LINE:      r = REG_LINE;
      OFF_BAUD:      r = REG_BAUD;
      OFF_FIFOCTL:   r = REG_FIFOCTL;
      OFF_MODEMCTL:  r = REG_MODEMCTL;
      OFF_TRSTAT:    r = REG_TRSTAT;
      OFF_FIFOSTAT:  r = REG_FIFOSTAT;
      OFF_ERRSTAT:   r = REG_ERRSTAT;
      OFF_MODEMSTAT: r = REG_MODEMSTAT;
      OFF_TXDATA:    r = REG_TXDATA;
      OFF_RXDATA:    r = REG_RXDATA;
      default:       r = REG_NONE;
    endcase
    return r;
  endfunction

  function automatic logic reg_readable(input reg_sel_e r);
    return (r != REG_NONE) && (r != REG_TXDATA);
  endfunction

  function automatic logic reg_writable(input reg_sel_e r);
    return (r != REG_NONE) && (r != REG_RXDATA);
  endfunction

endpackage

// File: rtl/uart_rst_sync.sv
module uart_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/uart_addr_decode.sv
module uart_addr_decode
  import uart_regif_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_CH-1:0] ch_oh,
  output reg_sel_e          sel,
  output logic              wr_ok,
  output logic              rd_ok
);
  localparam int unsigned IDX_W = ADDR_W - WIN_SHIFT;

  logic [IDX_W-1:0]     idx;
  logic [WIN_SHIFT-1:0] off;
  logic                 ch_in_range;

  assign idx         = bus_addr[ADDR_W-1:WIN_SHIFT];
  assign off         = bus_addr[WIN_SHIFT-1:0];
  assign sel         = offset_to_reg(off);
  assign ch_in_range = int'(idx) < NUM_CH;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    assign ch_oh[c] = (idx == IDX_W'(c));
  end

  assign wr_ok = bus_en &&  bus_we && ch_in_range && reg_writable(sel);
  assign rd_ok = bus_en && !bus_we && ch_in_range && reg_readable(sel);
endmodule

// File: rtl/uart_chan_regs.sv
module uart_chan_regs
  import uart_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [WORD_W-1:0] rd_word,
  output logic              tx_stb,
  output logic              tx_irq
);
  logic [WORD_W-1:0] ctrl_q, line_q, baud_q, fifoctl_q, modemctl_q;
  logic [WORD_W-1:0] trstat_q, fifostat_q, errstat_q, modemstat_q;
  logic [WORD_W-1:0] ctrl_d, line_d, baud_d, fifoctl_d, modemctl_d;
  logic [WORD_W-1:0] trstat_d, fifostat_d, errstat_d, modemstat_d;
  logic [BYTE_W-1:0] rxbuf_q, rxbuf_d;
  logic              tx_stb_d, tx_irq_d;
  logic              bank_en;

  assign bank_en = wr_en || rd_en || rx_valid;

  always_comb begin
    ctrl_d      = ctrl_q;
    line_d      = line_q;
    baud_d      = baud_q;
    fifoctl_d   = fifoctl_q;
    modemctl_d  = modemctl_q;
    trstat_d    = trstat_q;
    fifostat_d  = fifostat_q;
    errstat_d   = errstat_q;
    modemstat_d = modemstat_q;
    rxbuf_d     = rxbuf_q;
    tx_stb_d    = 1'b0;
    if (wr_en) begin
      case (sel)
        REG_CTRL:      ctrl_d      = wdata;
        REG_LINE:      line_d      = wdata;
        REG_BAUD:      baud_d      = wdata;
        REG_FIFOCTL:   fifoctl_d   = wdata;
        REG_MODEMCTL:  modemctl_d  = wdata;
        REG_TRSTAT:    trstat_d    = wdata;
        REG_FIFOSTAT:  fifostat_d  = wdata;
        REG_ERRSTAT:   errstat_d   = wdata;
        REG_MODEMSTAT: modemstat_d = wdata;
        REG_TXDATA: begin
          trstat_d = trstat_q | TX_EMPTY_SET;
          tx_stb_d = 1'b1;
        end
        default: ;
      endcase
    end
    if (rd_en && sel == REG_RXDATA) begin
      trstat_d[0]   = 1'b0;
      fifostat_d[0] = 1'b0;
    end
    if (rx_valid) begin
      trstat_d[0]   = 1'b1;
      fifostat_d[0] = 1'b1;
      rxbuf_d       = rx_byte;
    end
    tx_irq_d = tx_stb_d && (ctrl_q[3:2] == IRQ_MODE_PULSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      line_q      <= '0;
      baud_q      <= '0;
      fifoctl_q   <= '0;
      modemctl_q  <= '0;
      trstat_q    <= TRSTAT_RESET;
      fifostat_q  <= '0;
      errstat_q   <= '0;
      modemstat_q <= '0;
      rxbuf_q     <= '0;
    end else if (bank_en) begin
      ctrl_q      <= ctrl_d;
      line_q      <= line_d;
      baud_q      <= baud_d;
      fifoctl_q   <= fifoctl_d;
      modemctl_q  <= modemctl_d;
      trstat_q    <= trstat_d;
      fifostat_q  <= fifostat_d;
      errstat_q   <= errstat_d;
      modemstat_q <= modemstat_d;
      rxbuf_q     <= rxbuf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_stb <= 1'b0;
      tx_irq <= 1'b0;
    end else begin
      tx_stb <= tx_stb_d;
      tx_irq <= tx_irq_d;
    end
  end

  always_comb begin
    case (sel)
      REG_CTRL:      rd_word = ctrl_q;
      REG_LINE:      rd_word = line_q;
      REG_BAUD:      rd_word = baud_q;
      REG_FIFOCTL:   rd_word = fifoctl_q;
      REG_MODEMCTL:  rd_word = modemctl_q;
      REG_TRSTAT:    rd_word = trstat_q;
      REG_FIFOSTAT:  rd_word = fifostat_q;
      REG_ERRSTAT:   rd_word = errstat_q;
      REG_MODEMSTAT: rd_word = modemstat_q;
      REG_RXDATA:    rd_word = {{(WORD_W-BYTE_W){1'b0}}, rxbuf_q};
      default:       rd_word = '0;
    endcase
  end
endmodule

// File: rtl/uart_rdata_mux.sv
module uart_rdata_mux
  import uart_regif_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_ok,
  input  logic [NUM_CH-1:0]        ch_oh,
  input  logic [NUM_CH*WORD_W-1:0] words,
  output logic [WORD_W-1:0]        rdata
);
  logic [NUM_CH:0][WORD_W-1:0] acc;
  logic [WORD_W-1:0]           rdata_d;

  assign acc[0] = '0;
  for (genvar c = 0; c < NUM_CH; c++) begin : g_or
    assign acc[c+1] = acc[c] | (ch_oh[c] ? words[c*WORD_W +: WORD_W] : '0);
  end
  assign rdata_d = acc[NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_ok) rdata <= rdata_d;
  end
endmodule

// File: rtl/uart_chan_regif.sv
module uart_chan_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned ADDR_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_en,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [WORD_W-1:0]        bus_wdata,
  output logic [WORD_W-1:0]        bus_rdata,
  input  logic [NUM_CH-1:0]        rx_valid,
  input  logic [NUM_CH*BYTE_W-1:0] rx_byte,
  output logic [NUM_CH-1:0]        tx_stb,
  output logic [BYTE_W-1:0]        tx_byte,
  output logic [NUM_CH-1:0]        tx_irq
);
  logic                     rst_ni;
  logic [NUM_CH-1:0]        ch_oh;
  reg_sel_e                 sel;
  logic                     wr_ok, rd_ok;
  logic [NUM_CH*WORD_W-1:0] words;
  logic                     tx_load;

  uart_rst_sync rst_i (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  uart_addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dec_i (
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .ch_oh(ch_oh), .sel(sel), .wr_ok(wr_ok), .rd_ok(rd_ok)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    uart_chan_regs regs_i (
      .clk(clk), .rst_n(rst_ni),
      .wr_en(wr_ok && ch_oh[c]), .rd_en(rd_ok && ch_oh[c]),
      .sel(sel), .wdata(bus_wdata),
      .rx_valid(rx_valid[c]), .rx_byte(rx_byte[c*BYTE_W +: BYTE_W]),
      .rd_word(words[c*WORD_W +: WORD_W]),
      .tx_stb(tx_stb[c]), .tx_irq(tx_irq[c])
    );
  end

  uart_rdata_mux #(.NUM_CH(NUM_CH)) mux_i (
    .clk(clk), .rst_n(rst_ni), .rd_ok(rd_ok), .ch_oh(ch_oh),
    .words(words), .rdata(bus_rdata)
  );

  assign tx_load = wr_ok && (sel == REG_TXDATA);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      tx_byte <= '0;
    else if (tx_load) tx_byte <= bus_wdata[BYTE_W-1:0];
  end
endmodule

// File: rtl/uart_chan_regif_chk.sv
module uart_chan_regif_chk
  import uart_regif_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] tx_stb,
  input logic [NUM_CH-1:0] tx_irq
);
  logic     in_range, tx_wr, mapped_rd;
  reg_sel_e r;

  assign r         = offset_to_reg(bus_addr[WIN_SHIFT-1:0]);
  assign in_range  = int'(bus_addr[ADDR_W-1:WIN_SHIFT]) < NUM_CH;
  assign tx_wr     = bus_en && bus_we && in_range && (r == REG_TXDATA);
  assign mapped_rd = bus_en && !bus_we && in_range && reg_readable(r);

  // R4
  tx_write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> ($countones(tx_stb) == 1));

  // R4
  tx_stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_stb));

  // R8
  tx_stb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_stb != '0) |-> $past(tx_wr));

  // R5
  tx_irq_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_irq & ~tx_stb) == '0));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped_rd |=> $stable(bus_rdata));
endmodule

bind uart_chan_regif uart_chan_regif_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .tx_stb(tx_stb), .tx_irq(tx_irq)
);

// File: tb/uart_chan_regif_tb_top.sv
module uart_chan_regif_tb_top;
  localparam int NCH = 3;
  localparam logic [15:0] RW_OFF [9] = '{16'h000, 16'h004, 16'h008, 16'h00C,
                                         16'h010, 16'h014, 16'h018, 16'h01C, 16'h020};
  localparam logic [15:0] O_CTRL = 16'h000, O_TRS = 16'h014, O_FST = 16'h018;
  localparam logic [15:0] O_TX = 16'h024, O_RX = 16'h028;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             bus_en, bus_we;
  logic [15:0]      bus_addr;
  logic [31:0]      bus_wdata, bus_rdata;
  logic [NCH-1:0]   rx_valid, tx_stb, tx_irq;
  logic [NCH*8-1:0] rx_byte;
  logic [7:0]       tx_byte;

  int nchk = 0, nfail = 0;
  logic [NCH-1:0] stb_seen, irq_seen;
  logic [7:0]     byte_seen;
  logic [31:0]    rv;

  always #4 clk = ~clk;

  uart_chan_regif #(.NUM_CH(NCH), .ADDR_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_stb(tx_stb), .tx_byte(tx_byte), .tx_irq(tx_irq)
  );

  function automatic logic [15:0] ad(input int ch, input logic [15:0] off);
    return 16'(ch * 16'h4000) + off;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    stb_seen = tx_stb; irq_seen = tx_irq; byte_seen = tx_byte;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_en = 1'b0;
  endtask

  task automatic rx_pulse(input int ch, input logic [7:0] b);
    @(negedge clk); rx_valid[ch] = 1'b1; rx_byte[ch*8 +: 8] = b;
    @(negedge clk); rx_valid = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_valid = '0; rx_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 reset contents
    check("R3 rdata", bus_rdata, 32'h0);
    check("R3 tx_stb", 32'(tx_stb), 32'h0);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 9; k++) begin
        rd(ad(c, RW_OFF[k]), rv);
        check("R3 reg", rv, (RW_OFF[k] == O_TRS) ? 32'h6 : 32'h0);
      end

    // R2 readback sweep, R1 channel isolation
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < NCH; c++)
        for (int k = 0; k < 9; k++)
          wr(ad(c, RW_OFF[k]), (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0 :
             32'hA5A5_5A5A ^ 32'((c << 8) | k));
      for (int c = 0; c < NCH; c++)
        for (int k = 0; k < 9; k++) begin
          rd(ad(c, RW_OFF[k]), rv);
          check("R2 R1 readback", rv, (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0 :
                32'hA5A5_5A5A ^ 32'((c << 8) | k));
        end
    end

    // R4 R5 transmit strobe and interrupt mode
    for (int c = 0; c < NCH; c++)
      for (int m = 0; m < 4; m++) begin
        wr(ad(c, O_CTRL), 32'(m << 2) | 32'hF0);
        wr(ad(c, O_TRS), 32'h0000_0100);
        wr(ad(c, O_TX), 32'h1234_5600 | 32'(8'h30 + c*4 + m));
        check("R4 stb", 32'(stb_seen), 32'(1 << c));
        check("R4 byte", 32'(byte_seen), 32'(8'h30 + c*4 + m));
        check("R5 irq", 32'(irq_seen), (m == 1) ? 32'(1 << c) : 32'h0);
        @(negedge clk);
        check("R4 single pulse", 32'({tx_stb, tx_irq}), 32'h0);
        rd(ad(c, O_TRS), rv);
        check("R4 trstat", rv, 32'h0000_0106);
      end

    // R7 R6 receive path
    for (int c = 0; c < NCH; c++) begin
      wr(ad(c, O_TRS), 32'hF0);
      wr(ad(c, O_FST), 32'hF0);
      rx_pulse(c, 8'h80 + 8'(c));
      rd(ad(c, O_TRS), rv); check("R7 trstat set", rv, 32'hF1);
      rd(ad(c, O_FST), rv); check("R7 fifostat set", rv, 32'hF1);
      rd(ad(c, O_RX), rv);  check("R6 rx data", rv, 32'h80 + 32'(c));
      rd(ad(c, O_TRS), rv); check("R6 trstat clr", rv, 32'hF0);
      rd(ad(c, O_FST), rv); check("R6 fifostat clr", rv, 32'hF0);
    end

    // R7 same-cycle receive and read
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = ad(1, O_RX);
    rx_valid[1] = 1'b1; rx_byte[15:8] = 8'h5C;
    @(negedge clk);
    rv = bus_rdata; bus_en = 1'b0; rx_valid = '0;
    check("R7 old byte", rv, 32'h81);
    rd(ad(1, O_TRS), rv); check("R7 set wins", rv, 32'hF1);
    rd(ad(1, O_RX), rv);  check("R7 new byte", rv, 32'h5C);

    // R8 unmapped and out-of-range accesses
    wr(ad(0, O_CTRL), 32'hCAFE_0001);
    wr(ad(3, O_CTRL), 32'hDEAD_BEEF);
    wr(ad(3, O_TX), 32'h77);
    check("R8 no stb", 32'(stb_seen), 32'h0);
    wr(ad(0, 16'h02C), 32'h1111_1111);
    wr(ad(0, O_RX), 32'h55);
    rd(ad(0, O_CTRL), rv); check("R8 R1 ch0 ctrl", rv, 32'hCAFE_0001);
    rd(ad(2, O_CTRL), rv); check("R1 ch2 ctrl", rv, 32'hF4 | 32'(3 << 2));
    rd(ad(0, O_RX), rv);   check("R8 rx write ignored", rv, 32'h80);
    rd(ad(0, O_CTRL), rv);
    rd(ad(0, O_TX), rv);        check("R8 tx read", rv, 32'hCAFE_0001);
    rd(ad(0, 16'h02C), rv);     check("R8 unmapped read", rv, 32'hCAFE_0001);
    rd(ad(3, O_CTRL), rv);      check("R8 range read", rv, 32'hCAFE_0001);
    rd(ad(0, 16'h3FFC), rv);    check("R8 top read", rv, 32'hCAFE_0001);

    // R9 idle hold
    repeat (5) @(negedge clk);
    check("R9 hold", bus_rdata, 32'hCAFE_0001);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule